// File: doc/BRIEF.md
# DRAM Cycle Classifier

This block sits on the device side of an asynchronous DRAM control bus. It watches the row strobe, column strobe, write enable and output enable. A fast sample clock oversamples all four, together with the multiplexed address pins. The block names each memory cycle from the order in which those pins change. It is meant to feed a DRAM behavioural model or a bus monitor. The block looks only at pin edges and holds no storage array.

All pins pass through two-flop synchronisers. Edges are found on the synchronised values. A falling row strobe opens a cycle. The column strobe level just before that edge selects a row access or a refresh. Within a row access, each column strobe pulse is one column access. The write-enable level at the column strobe fall, or a later write-enable fall, decides between read, early write, output-enable-controlled write and read-modify-write. The output enable also plays a part. Refresh cycles take their row from an internal counter that wraps.

Each classified cycle gives a one-cycle `cyc_valid` pulse with a 4-bit code and the row and column values that were latched. The codes are: 1 read, 2 early write, 3 output-enable-controlled write, 4 read-modify-write, 5 row-strobe-only refresh, 6 column-before-row refresh, 7 self-refresh, 8 test-mode entry, 9 hidden refresh. Code 0 is never reported.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset `cyc_valid` is low and the refresh row counter is zero, so the first refresh reports row 0.
- R2: A row strobe fall with the column strobe high latches the address as the row. The next column strobe fall latches the low COL_W address bits as the column. If write enable stays high, that column access is reported as code 1 when the column strobe rises.
- R3: If write enable is already low when the column strobe falls, the column access is reported as code 2.
- R4: If write enable falls while the column strobe is low, and output enable was not seen low before that fall, the access is reported as code 3.
- R5: If output enable is seen low during the column strobe pulse and write enable falls afterwards, the access is reported as code 4.
- R6: Several column strobe pulses under one row strobe low period are each reported separately, in order, with the same row.
- R7: A row strobe low period with no column strobe fall is reported at the row strobe rise as code 5, with the latched row.
- R8: A row strobe fall with the column strobe low and write enable high is a refresh. It reports the counter value as its row, and the counter then advances by one, modulo 2^ADDR_W. This is code 6 when the row strobe was low for fewer than SELF_CYC samples.
- R9: The same refresh with the row strobe low for SELF_CYC samples or more is reported as code 7. SELF_CYC-1 samples still gives code 6.
- R10: A row strobe fall with both the column strobe and write enable low is reported as code 8 with row 0. It does not advance the refresh counter.
- R11: If the row strobe rises during a column access while the column strobe stays low, the access is reported at that rise. The next row strobe fall is then a hidden refresh: it reports code 9 with the counter row and advances the counter.
- R12: `cyc_valid` is a single-cycle pulse, the code is always in 1..9, and the column field is 0 for codes 5 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_strobe_n | input | 1 | Row address strobe, active low |
| col_strobe_n | input | 1 | Column address strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| mux_addr | input | ADDR_W | Multiplexed row/column address pins |
| cyc_valid | output | 1 | One-cycle pulse per classified cycle |
| cyc_type | output | 4 | Cycle code (1..9) |
| cyc_row | output | ADDR_W | Latched row or refresh counter row |
| cyc_col | output | COL_W | Latched column, 0 for non-access cycles |

## Verification
The checks take two things for granted about the inputs. First, any two control pin changes are at least two sample clocks apart. Second, the address is stable around the strobe edges. With these, the synchronisers keep the order of edges, and no two reports can fall on adjacent cycles. The stimulus holds every pin level for at least two to three sample clocks and changes the address only while both strobes are idle. This applies to the directed corner cases (self-refresh threshold, counter wrap, hidden refresh) and to the random row, refresh and page sequences alike.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  localparam int CTRL_W = 4;
  localparam int IX_RAS = 0;
  localparam int IX_CAS = 1;
  localparam int IX_WE  = 2;
  localparam int IX_OE  = 3;

  typedef enum logic [3:0] {
    CK_NONE    = 4'd0,
    CK_READ    = 4'd1,
    CK_EWRITE  = 4'd2,
    CK_OEWRITE = 4'd3,
    CK_RMW     = 4'd4,
    CK_RASONLY = 4'd5,
    CK_CBR     = 4'd6,
    CK_SELF    = 4'd7,
    CK_TEST    = 4'd8,
    CK_HIDDEN  = 4'd9
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_HWAIT,
    ST_REF
  } phase_e;
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/dcc_edge.sv
`timescale 1ns/1ps
module dcc_edge #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prv,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [W-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= RST_VAL;
    else        prv_q <= cur;
  end

  assign prv  = prv_q;
  assign fall = prv_q & ~cur;
  assign rise = ~prv_q & cur;
endmodule

// File: rtl/dcc_refresh_ctr.sv
`timescale 1ns/1ps
module dcc_refresh_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (adv) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dcc_classifier.sv
`timescale 1ns/1ps
module dcc_classifier
  import dcc_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CW       = 10,
  parameter int SELF_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] lvl,
  input  logic [CTRL_W-1:0] prv,
  input  logic [CTRL_W-1:0] fall,
  input  logic [CTRL_W-1:0] rise,
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     ref_row,
  output logic              ref_adv,
  output logic              cyc_valid,
  output logic [3:0]        cyc_type,
  output logic [AW-1:0]     cyc_row,
  output logic [CW-1:0]     cyc_col
);
  localparam int CNT_W = $clog2(SELF_CYC + 1);
  localparam logic [CNT_W-1:0] SELF_LIM = CNT_W'(SELF_CYC);

  phase_e           st_q, st_n;
  logic [AW-1:0]    row_q, row_n;
  logic [CW-1:0]    col_q, col_n;
  logic             early_q, early_n;
  logic             late_q, late_n;
  logic             oe_seen_q, oe_seen_n;
  logic             seen_cas_q, seen_cas_n;
  cyc_kind_e        rk_q, rk_n;
  logic [CNT_W-1:0] lc_q, lc_n;
  logic             v_q, v_n;
  cyc_kind_e        k_q, k_n;
  logic [AW-1:0]    orow_q, orow_n;
  logic [CW-1:0]    ocol_q, ocol_n;

  logic ras_f, ras_r, cas_f, cas_r, we_f;
  logic late_now;
  cyc_kind_e acc_k;
  cyc_kind_e ref_k;
  logic edge_unused;

  assign ras_f = fall[IX_RAS];
  assign ras_r = rise[IX_RAS];
  assign cas_f = fall[IX_CAS];
  assign cas_r = rise[IX_CAS];
  assign we_f  = fall[IX_WE];
  assign edge_unused = ^{fall[IX_OE], rise[IX_WE], rise[IX_OE],
                         prv[IX_RAS], prv[IX_WE], prv[IX_OE]};

  // a write enable fall inside the column pulse marks a late write
  assign late_now = late_q | (we_f & ~early_q);

  always_comb begin
    if (early_q)       acc_k = CK_EWRITE;
    else if (late_now) acc_k = oe_seen_q ? CK_RMW : CK_OEWRITE;
    else               acc_k = CK_READ;
  end

  always_comb begin
    if (rk_q == CK_CBR && lc_q >= SELF_LIM) ref_k = CK_SELF;
    else                                    ref_k = rk_q;
  end

  always_comb begin
    st_n       = st_q;
    row_n      = row_q;
    col_n      = col_q;
    early_n    = early_q;
    late_n     = late_q;
    oe_seen_n  = oe_seen_q;
    seen_cas_n = seen_cas_q;
    rk_n       = rk_q;
    lc_n       = lc_q;
    v_n        = 1'b0;
    k_n        = k_q;
    orow_n     = orow_q;
    ocol_n     = ocol_q;
    ref_adv    = 1'b0;

    case (st_q)
      ST_IDLE, ST_HWAIT: begin
        if (ras_f) begin
          lc_n = CNT_W'(1);
          if (st_q == ST_HWAIT) begin
            rk_n    = CK_HIDDEN;
            row_n   = ref_row;
            ref_adv = 1'b1;
            st_n    = ST_REF;
          end else if (prv[IX_CAS]) begin
            row_n      = addr;
            seen_cas_n = 1'b0;
            st_n       = ST_ROW;
          end else if (!lvl[IX_WE]) begin
            rk_n  = CK_TEST;
            row_n = '0;
            st_n  = ST_REF;
          end else begin
            rk_n    = CK_CBR;
            row_n   = ref_row;
            ref_adv = 1'b1;
            st_n    = ST_REF;
          end
        end else if (st_q == ST_HWAIT && cas_r) begin
          st_n = ST_IDLE;
        end
      end

      ST_ROW: begin
        if (cas_f) begin
          col_n      = addr[CW-1:0];
          early_n    = ~lvl[IX_WE];
          late_n     = 1'b0;
          oe_seen_n  = 1'b0;
          seen_cas_n = 1'b1;
          st_n       = ST_COL;
        end else if (ras_r) begin
          if (!seen_cas_q) begin
            v_n    = 1'b1;
            k_n    = CK_RASONLY;
            orow_n = row_q;
            ocol_n = '0;
          end
          st_n = ST_IDLE;
        end
      end

      ST_COL: begin
        late_n = late_now;
        if (!lvl[IX_OE] && !late_now) oe_seen_n = 1'b1;
        if (cas_r || ras_r) begin
          v_n    = 1'b1;
          k_n    = acc_k;
          orow_n = row_q;
          ocol_n = col_q;
          st_n   = cas_r ? ST_ROW : ST_HWAIT;
        end
      end

      ST_REF: begin
        if (ras_r) begin
          v_n    = 1'b1;
          k_n    = ref_k;
          orow_n = row_q;
          ocol_n = '0;
          st_n   = (rk_q == CK_HIDDEN && !lvl[IX_CAS]) ? ST_HWAIT : ST_IDLE;
        end else if (!lvl[IX_RAS] && lc_q != SELF_LIM) begin
          lc_n = lc_q + 1'b1;
        end
      end

      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      early_q    <= 1'b0;
      late_q     <= 1'b0;
      oe_seen_q  <= 1'b0;
      seen_cas_q <= 1'b0;
      rk_q       <= CK_NONE;
      lc_q       <= '0;
      v_q        <= 1'b0;
      k_q        <= CK_NONE;
      orow_q     <= '0;
      ocol_q     <= '0;
    end else begin
      st_q       <= st_n;
      row_q      <= row_n;
      col_q      <= col_n;
      early_q    <= early_n;
      late_q     <= late_n;
      oe_seen_q  <= oe_seen_n;
      seen_cas_q <= seen_cas_n;
      rk_q       <= rk_n;
      lc_q       <= lc_n;
      v_q        <= v_n;
      k_q        <= k_n;
      orow_q     <= orow_n;
      ocol_q     <= ocol_n;
    end
  end

  assign cyc_valid = v_q;
  assign cyc_type  = k_q;
  assign cyc_row   = orow_q;
  assign cyc_col   = ocol_q;
endmodule

// File: rtl/dram_cycle_classifier.sv
`timescale 1ns/1ps
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int COL_W    = 10,
  parameter int SELF_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] mux_addr,
  output logic              cyc_valid,
  output logic [3:0]        cyc_type,
  output logic [ADDR_W-1:0] cyc_row,
  output logic [COL_W-1:0]  cyc_col
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s, ctrl_p, ctrl_f, ctrl_r;
  logic [ADDR_W-1:0] addr_s;
  logic [ADDR_W-1:0] ref_cnt;
  logic              ref_adv;

  assign ctrl_raw = {out_en_n, wr_en_n, col_strobe_n, row_strobe_n};

  dcc_sync #(.W(CTRL_W), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s));

  dcc_sync #(.W(ADDR_W), .RST_VAL({ADDR_W{1'b0}})) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(mux_addr), .q(addr_s));

  dcc_edge #(.W(CTRL_W), .RST_VAL({CTRL_W{1'b1}})) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(ctrl_s), .prv(ctrl_p),
    .fall(ctrl_f), .rise(ctrl_r));

  dcc_refresh_ctr #(.W(ADDR_W)) u_rctr (
    .clk(clk), .rst_n(rst_n), .adv(ref_adv), .cnt(ref_cnt));

  dcc_classifier #(.AW(ADDR_W), .CW(COL_W), .SELF_CYC(SELF_CYC)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .lvl(ctrl_s), .prv(ctrl_p), .fall(ctrl_f), .rise(ctrl_r),
    .addr(addr_s), .ref_row(ref_cnt), .ref_adv(ref_adv),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_row(cyc_row), .cyc_col(cyc_col));
endmodule

// File: rtl/dcc_checker.sv
`timescale 1ns/1ps
module dcc_checker #(
  parameter int AW = 12,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_valid,
  input logic [3:0]    cyc_type,
  input logic [AW-1:0] cyc_row,
  input logic [CW-1:0] cyc_col,
  input logic [AW-1:0] ref_cnt
);
  // R12
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  // R12
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_type >= 4'd1 && cyc_type <= 4'd9));

  // R12
  nonaccess_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type >= 4'd5) |-> cyc_col == '0);

  // R8
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt != $past(ref_cnt)) |-> ref_cnt == AW'($past(ref_cnt) + AW'(1)));

  // R8
  refresh_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_type == 4'd6 || cyc_type == 4'd7 || cyc_type == 4'd9))
      |-> cyc_row == AW'(ref_cnt - AW'(1)));
endmodule

bind dram_cycle_classifier dcc_checker #(.AW(ADDR_W), .CW(COL_W)) u_dcc_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
  .cyc_row(cyc_row), .cyc_col(cyc_col), .ref_cnt(ref_cnt));

// File: tb/test_dram_cycle_classifier.sv
`timescale 1ns/1ps
module test_dram_cycle_classifier;
  localparam int AW = 4;
  localparam int CW = 3;
  localparam int SC = 40;
  localparam int EW = 4 + AW + CW;

  logic clk = 1'b0;
  logic rst_n, rs_n, cs_n, we_n, oe_n;
  logic [AW-1:0] ma;
  logic          cyc_valid;
  logic [3:0]    cyc_type;
  logic [AW-1:0] cyc_row;
  logic [CW-1:0] cyc_col;

  int checks = 0;
  int errors = 0;
  int dbl_pulse = 0;
  logic prev_valid = 1'b0;
  logic [AW-1:0] ref_model = '0;
  logic [EW-1:0] evq[$];

  always #2.5 clk = ~clk;

  dram_cycle_classifier #(.ADDR_W(AW), .COL_W(CW), .SELF_CYC(SC)) i_dram_cycle_classifier (
    .clk(clk), .rst_n(rst_n), .row_strobe_n(rs_n), .col_strobe_n(cs_n),
    .wr_en_n(we_n), .out_en_n(oe_n), .mux_addr(ma),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_row(cyc_row), .cyc_col(cyc_col));

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc_valid) evq.push_back({cyc_type, cyc_row, cyc_col});
      if (cyc_valid && prev_valid) dbl_pulse++;
      prev_valid <= cyc_valid;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [3:0] k, input logic [AW-1:0] r,
                           input logic [CW-1:0] c, input string tag);
    logic [EW-1:0] e;
    wt(6);
    if (evq.size() == 0) begin
      chk(1'b0, {tag, " missing report"}, -1, int'(k));
    end else begin
      e = evq.pop_front();
      chk(e[EW-1 -: 4] == k, {tag, " type"}, int'(e[EW-1 -: 4]), int'(k));
      chk(e[AW+CW-1 -: AW] == r, {tag, " row"}, int'(e[AW+CW-1 -: AW]), int'(r));
      chk(e[CW-1:0] == c, {tag, " col"}, int'(e[CW-1:0]), int'(c));
    end
  endtask

  function automatic logic [3:0] acc_code(input int mode);
    case (mode)
      1:       return 4'd2;
      2:       return 4'd3;
      3:       return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  task automatic row_open(input logic [AW-1:0] r);
    ma = r; wt(2); rs_n = 1'b0; wt(3);
  endtask

  task automatic row_close();
    rs_n = 1'b1; wt(3);
  endtask

  // mode: 0 read, 1 early write, 2 output-enable write, 3 read-modify-write
  task automatic col_acc(input logic [AW-1:0] c, input int mode, input bit keep);
    ma = c;
    if (mode == 1) we_n = 1'b0;
    wt(3);
    cs_n = 1'b0; wt(3);
    case (mode)
      0: begin oe_n = 1'b0; wt(3); oe_n = 1'b1; wt(2); end
      2: begin we_n = 1'b0; wt(3); end
      3: begin oe_n = 1'b0; wt(3); oe_n = 1'b1; wt(3); we_n = 1'b0; wt(3); end
      default: wt(3);
    endcase
    if (!keep) begin cs_n = 1'b1; wt(3); end
    we_n = 1'b1; wt(3);
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    ma = r; wt(2); rs_n = 1'b0; wt(5); rs_n = 1'b1; wt(3);
  endtask

  task automatic cbr(input int n, input bit test);
    cs_n = 1'b0;
    if (test) we_n = 1'b0;
    wt(3);
    rs_n = 1'b0; wt(n); rs_n = 1'b1; wt(3);
    cs_n = 1'b1; we_n = 1'b1; wt(3);
  endtask

  task automatic cbr_expect(input int n, input string tag);
    cbr(n, 1'b0);
    expect_ev((n >= SC) ? 4'd7 : 4'd6, ref_model, '0, tag);
    ref_model = ref_model + 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] r;
    logic [AW-1:0] c;
    int m;
    void'($urandom(32'd1103));
    rst_n = 1'b0; rs_n = 1'b1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ma = '0;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    chk(cyc_valid == 1'b0, "R1 valid after reset", int'(cyc_valid), 0);
    cbr_expect(8, "R1 first refresh row zero");

    row_open(4'd9); col_acc(4'd5, 0, 1'b0); row_close();
    expect_ev(4'd1, 4'd9, 3'd5, "R2 read");
    row_open(4'd3); col_acc(4'd6, 1, 1'b0); row_close();
    expect_ev(4'd2, 4'd3, 3'd6, "R3 early write");
    row_open(4'd12); col_acc(4'd2, 2, 1'b0); row_close();
    expect_ev(4'd3, 4'd12, 3'd2, "R4 oe write");
    row_open(4'd7); col_acc(4'd7, 3, 1'b0); row_close();
    expect_ev(4'd4, 4'd7, 3'd7, "R5 read-modify-write");

    row_open(4'd10);
    col_acc(4'd1, 0, 1'b0); col_acc(4'd4, 1, 1'b0); col_acc(4'd11, 3, 1'b0);
    row_close();
    expect_ev(4'd1, 4'd10, 3'd1, "R6 page first");
    expect_ev(4'd2, 4'd10, 3'd4, "R6 page second");
    expect_ev(4'd4, 4'd10, 3'd3, "R6 page third");

    ras_only(4'd14);
    expect_ev(4'd5, 4'd14, 3'd0, "R7 row-strobe-only refresh R12 col zero");

    cbr_expect(6, "R8 refresh");
    cbr_expect(SC - 1, "R9 below threshold");
    cbr_expect(SC, "R9 at threshold");
    cbr_expect(SC + 7, "R9 above threshold");

    cbr(10, 1'b1);
    expect_ev(4'd8, 4'd0, 3'd0, "R10 test entry");
    cbr_expect(6, "R10 counter not advanced");

    row_open(4'd6); col_acc(4'd3, 0, 1'b1);
    rs_n = 1'b1; wt(3);
    expect_ev(4'd1, 4'd6, 3'd3, "R11 access before hidden");
    rs_n = 1'b0; wt(6); rs_n = 1'b1; wt(3);
    expect_ev(4'd9, ref_model, 3'd0, "R11 hidden refresh");
    ref_model = ref_model + 1'b1;
    cs_n = 1'b1; wt(4);
    chk(evq.size() == 0, "R11 no report on column release", evq.size(), 0);

    for (int i = 0; i < 17; i++) cbr_expect(5 + i, "R8 counter wrap");

    for (int i = 0; i < 60; i++) begin
      case ($urandom % 4)
        0, 1: begin
          r = AW'($urandom);
          row_open(r);
          c = AW'($urandom); m = int'($urandom % 4);
          col_acc(c, m, 1'b0);
          row_close();
          expect_ev(acc_code(m), r, c[CW-1:0], "R2 R3 R4 R5 random access");
        end
        2: begin
          r = AW'($urandom);
          ras_only(r);
          expect_ev(4'd5, r, 3'd0, "R7 random");
        end
        default: cbr_expect(4 + int'($urandom % 50), "R8 R9 random refresh");
      endcase
    end

    wt(5);
    chk(dbl_pulse == 0, "R12 single-cycle pulse", dbl_pulse, 0);
    chk(evq.size() == 0, "R12 no spurious reports", evq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule